// File: doc/BRIEF.md
# Three-Field Microoperation Datapath

This block is the register-transfer half of a small microprogrammed machine. Each clock cycle it receives three 3-bit encoded microoperation fields. Each field is decoded through its own table into transfers on a shared set of registers:

- a 16-bit accumulator;
- a 16-bit data register;
- an 11-bit address register;
- an 11-bit program counter;
- a word-addressed main memory of 2^11 words of 16 bits, held inside the block.

All three fields act in the same cycle. Every transfer reads the register values from before the clock edge, and all results land on that one edge.

The block also provides three status bits for an external sequencer to test:

- the data register's top bit, which is the indirect flag of a machine word whose bit 15 is the indirect flag, bits 14..11 the opcode and bits 10..0 the address;
- the accumulator sign;
- an accumulator-is-zero flag.

Register contents are also visible at the ports. Microinstruction sequencing and control storage live outside the block.

Top module: `mpdp_top`

## Requirements
- R1: While `rst_n` is low, the four registers and every memory word are cleared to 0, so `zero_o`=1, `sgn_o`=0 and `ind_o`=0.
- R2: First field `f1` codes 1 to 4 load the accumulator with, in order, AC+DR, 0, AC+1 and DR. Sums wrap modulo 2^16 and no carry is kept.
- R3: First field code 5 loads AR with DR[10:0]. Code 6 loads AR with PC.
- R4: First field code 7 writes DR into memory word M[AR] at the clock edge. The word is later observable through the read transfer of R6.
- R5: Second field `f2` codes 1 to 3 load the accumulator with, in order, AC−DR (modulo 2^16), AC OR DR and AC AND DR.
- R6: Second field codes 4 to 7 load DR with, in order, M[AR] (the value stored before this edge), AC and DR+1 (modulo 2^16). Code 7 replaces DR[10:0] with PC and leaves DR[15:11] unchanged.
- R7: Third field `f3` codes 1 to 4 load the accumulator with, in order, AC XOR DR, NOT AC, AC shifted left by one and AC shifted right by one. Both shifts fill the vacated bit with 0.
- R8: Third field code 5 increments PC modulo 2^11. Code 6 loads PC with AR. Code 7 is reserved and changes nothing.
- R9: Transfers named by different fields in one microinstruction all use the pre-edge register values and complete on the same edge. An example is a memory read together with a PC increment.
- R10: `ind_o` equals DR[15], `sgn_o` equals AC[15], and `zero_o` is 1 exactly when AC is 0.
- R11: When more than one field targets the same register, the first field wins over the second and the second over the third.
- R12: A microinstruction with all three fields at 0 leaves every register and the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers and memory writes act on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| f1 | input | 3 | First microoperation field |
| f2 | input | 3 | Second microoperation field |
| f3 | input | 3 | Third microoperation field |
| ac_o | output | 16 | Accumulator contents |
| dr_o | output | 16 | Data register contents |
| ar_o | output | 11 | Address register contents |
| pc_o | output | 11 | Program counter contents |
| ind_o | output | 1 | Indirect status, DR bit 15 |
| sgn_o | output | 1 | Accumulator sign |
| zero_o | output | 1 | Accumulator equals zero |

## Verification
On every cycle, the assertions check several behaviours:

- the accumulator clear in the first field beats any other accumulator action;
- PC stepping and the AR/DR copies use the old values;
- a right shift leaves the top bit clear;
- an all-NOP cycle holds every register;
- a write code always produces a memory write;
- the sign and zero flags never both show.

The full arithmetic tables need the bench's reference model and its scenarios. These include wrap-around of the sums and of PC, preservation of DR[15:11], the memory write-then-read round trip, and many random field combinations. The priority rule for clashing fields likewise needs a scenario.

// File: rtl/mpdp_pkg.sv
package mpdp_pkg;
  localparam int FIELD_W   = 3;
  localparam int NUM_SLOTS = 3;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 11;

  typedef enum logic [FIELD_W-1:0] {
    A_NOP = 3'd0, A_ADD = 3'd1, A_CLR = 3'd2, A_INC = 3'd3,
    A_LDD = 3'd4, A_ARD = 3'd5, A_ARP = 3'd6, A_WR  = 3'd7
  } f1_op_e;

  typedef enum logic [FIELD_W-1:0] {
    B_NOP = 3'd0, B_SUB = 3'd1, B_OR  = 3'd2, B_AND = 3'd3,
    B_RD  = 3'd4, B_DAC = 3'd5, B_DIN = 3'd6, B_DPC = 3'd7
  } f2_op_e;

  typedef enum logic [FIELD_W-1:0] {
    C_NOP = 3'd0, C_XOR = 3'd1, C_NOT = 3'd2, C_SHL = 3'd3,
    C_SHR = 3'd4, C_PCI = 3'd5, C_PCA = 3'd6, C_RSV = 3'd7
  } f3_op_e;
endpackage

// File: rtl/mpdp_dec.sv
module mpdp_dec
  import mpdp_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  localparam int NS = NUM_SLOTS
) (
  input  logic [FIELD_W-1:0]      f1,
  input  logic [FIELD_W-1:0]      f2,
  input  logic [FIELD_W-1:0]      f3,
  input  logic [DW-1:0]           ac,
  input  logic [DW-1:0]           dr,
  input  logic [AW-1:0]           ar,
  input  logic [AW-1:0]           pc,
  input  logic [DW-1:0]           mrd,
  output logic [NS-1:0]           ac_req,
  output logic [NS-1:0][DW-1:0]   ac_cand,
  output logic [NS-1:0]           dr_req,
  output logic [NS-1:0][DW-1:0]   dr_cand,
  output logic [NS-1:0]           ar_req,
  output logic [NS-1:0][AW-1:0]   ar_cand,
  output logic [NS-1:0]           pc_req,
  output logic [NS-1:0][AW-1:0]   pc_cand,
  output logic                    mem_we
);
  // arithmetic helpers, all truncating to the register width
  function automatic logic [DW-1:0] add_w(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction
  function automatic logic [DW-1:0] sub_w(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a - b;
  endfunction
  function automatic logic [DW-1:0] shl_w(input logic [DW-1:0] a);
    return {a[DW-2:0], 1'b0};
  endfunction
  function automatic logic [DW-1:0] shr_w(input logic [DW-1:0] a);
    return {1'b0, a[DW-1:1]};
  endfunction
  function automatic logic [AW-1:0] inc_a(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  // slot 0: first field
  always_comb begin
    ac_req[0]  = 1'b0;  ac_cand[0] = ac;
    ar_req[0]  = 1'b0;  ar_cand[0] = ar;
    dr_req[0]  = 1'b0;  dr_cand[0] = dr;
    pc_req[0]  = 1'b0;  pc_cand[0] = pc;
    mem_we     = 1'b0;
    case (f1_op_e'(f1))
      A_ADD: begin ac_req[0] = 1'b1; ac_cand[0] = add_w(ac, dr);     end
      A_CLR: begin ac_req[0] = 1'b1; ac_cand[0] = '0;                end
      A_INC: begin ac_req[0] = 1'b1; ac_cand[0] = add_w(ac, DW'(1)); end
      A_LDD: begin ac_req[0] = 1'b1; ac_cand[0] = dr;                end
      A_ARD: begin ar_req[0] = 1'b1; ar_cand[0] = dr[AW-1:0];        end
      A_ARP: begin ar_req[0] = 1'b1; ar_cand[0] = pc;                end
      A_WR:  mem_we = 1'b1;
      default: ;
    endcase
  end

  // slot 1: second field
  always_comb begin
    ac_req[1]  = 1'b0;  ac_cand[1] = ac;
    dr_req[1]  = 1'b0;  dr_cand[1] = dr;
    ar_req[1]  = 1'b0;  ar_cand[1] = ar;
    pc_req[1]  = 1'b0;  pc_cand[1] = pc;
    case (f2_op_e'(f2))
      B_SUB: begin ac_req[1] = 1'b1; ac_cand[1] = sub_w(ac, dr);     end
      B_OR:  begin ac_req[1] = 1'b1; ac_cand[1] = ac | dr;           end
      B_AND: begin ac_req[1] = 1'b1; ac_cand[1] = ac & dr;           end
      B_RD:  begin dr_req[1] = 1'b1; dr_cand[1] = mrd;               end
      B_DAC: begin dr_req[1] = 1'b1; dr_cand[1] = ac;                end
      B_DIN: begin dr_req[1] = 1'b1; dr_cand[1] = add_w(dr, DW'(1)); end
      B_DPC: begin dr_req[1] = 1'b1; dr_cand[1] = {dr[DW-1:AW], pc}; end
      default: ;
    endcase
  end

  // slot 2: third field
  always_comb begin
    ac_req[2]  = 1'b0;  ac_cand[2] = ac;
    dr_req[2]  = 1'b0;  dr_cand[2] = dr;
    ar_req[2]  = 1'b0;  ar_cand[2] = ar;
    pc_req[2]  = 1'b0;  pc_cand[2] = pc;
    case (f3_op_e'(f3))
      C_XOR: begin ac_req[2] = 1'b1; ac_cand[2] = ac ^ dr;    end
      C_NOT: begin ac_req[2] = 1'b1; ac_cand[2] = ~ac;        end
      C_SHL: begin ac_req[2] = 1'b1; ac_cand[2] = shl_w(ac);  end
      C_SHR: begin ac_req[2] = 1'b1; ac_cand[2] = shr_w(ac);  end
      C_PCI: begin pc_req[2] = 1'b1; pc_cand[2] = inc_a(pc);  end
      C_PCA: begin pc_req[2] = 1'b1; pc_cand[2] = ar;         end
      default: ;  // reserved code and NOP
    endcase
  end
endmodule

// File: rtl/mpdp_arb.sv
module mpdp_arb #(
  parameter int W = 16,
  parameter int N = 3
) (
  input  logic [N-1:0]        req,
  input  logic [N-1:0][W-1:0] cand,
  input  logic [W-1:0]        hold,
  output logic                load,
  output logic [W-1:0]        nxt
);
  // lowest slot index wins: scan from the weakest slot upward in strength
  always_comb begin
    load = 1'b0;
    nxt  = hold;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) begin
        load = 1'b1;
        nxt  = cand[k];
      end
    end
  end
endmodule

// File: rtl/mpdp_mem.sv
module mpdp_mem #(
  parameter int DW = 16,
  parameter int AW = 11,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  assign rdata = mem_q[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[addr] <= wdata;
    end
  end
endmodule

// File: rtl/mpdp_top.sv
module mpdp_top
  import mpdp_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    f1,
  input  logic [2:0]    f2,
  input  logic [2:0]    f3,
  output logic [DW-1:0] ac_o,
  output logic [DW-1:0] dr_o,
  output logic [AW-1:0] ar_o,
  output logic [AW-1:0] pc_o,
  output logic          ind_o,
  output logic          sgn_o,
  output logic          zero_o
);
  localparam int NS = NUM_SLOTS;

  logic [DW-1:0] ac_q, dr_q, mrd;
  logic [AW-1:0] ar_q, pc_q;

  logic [NS-1:0]         ac_req, dr_req, ar_req, pc_req;
  logic [NS-1:0][DW-1:0] ac_cand, dr_cand;
  logic [NS-1:0][AW-1:0] ar_cand, pc_cand;

  // named internal events
  logic          ac_load, dr_load, ar_load, pc_load, mem_wr;
  logic [DW-1:0] ac_next, dr_next;
  logic [AW-1:0] ar_next, pc_next;

  mpdp_dec #(.DW(DW), .AW(AW)) u_dec (
    .f1(f1), .f2(f2), .f3(f3),
    .ac(ac_q), .dr(dr_q), .ar(ar_q), .pc(pc_q), .mrd(mrd),
    .ac_req(ac_req), .ac_cand(ac_cand),
    .dr_req(dr_req), .dr_cand(dr_cand),
    .ar_req(ar_req), .ar_cand(ar_cand),
    .pc_req(pc_req), .pc_cand(pc_cand),
    .mem_we(mem_wr)
  );

  mpdp_arb #(.W(DW), .N(NS)) u_arb_ac (
    .req(ac_req), .cand(ac_cand), .hold(ac_q), .load(ac_load), .nxt(ac_next));
  mpdp_arb #(.W(DW), .N(NS)) u_arb_dr (
    .req(dr_req), .cand(dr_cand), .hold(dr_q), .load(dr_load), .nxt(dr_next));
  mpdp_arb #(.W(AW), .N(NS)) u_arb_ar (
    .req(ar_req), .cand(ar_cand), .hold(ar_q), .load(ar_load), .nxt(ar_next));
  mpdp_arb #(.W(AW), .N(NS)) u_arb_pc (
    .req(pc_req), .cand(pc_cand), .hold(pc_q), .load(pc_load), .nxt(pc_next));

  mpdp_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_wr), .addr(ar_q), .wdata(dr_q), .rdata(mrd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q <= '0;
      dr_q <= '0;
      ar_q <= '0;
      pc_q <= '0;
    end else begin
      if (ac_load) ac_q <= ac_next;
      if (dr_load) dr_q <= dr_next;
      if (ar_load) ar_q <= ar_next;
      if (pc_load) pc_q <= pc_next;
    end
  end

  assign ac_o   = ac_q;
  assign dr_o   = dr_q;
  assign ar_o   = ar_q;
  assign pc_o   = pc_q;
  assign ind_o  = dr_q[DW-1];
  assign sgn_o  = ac_q[DW-1];
  assign zero_o = (ac_q == '0);
endmodule

// File: rtl/mpdp_chk.sv
module mpdp_chk #(
  parameter int DW = 16,
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    f1,
  input logic [2:0]    f2,
  input logic [2:0]    f3,
  input logic [DW-1:0] ac_o,
  input logic [DW-1:0] dr_o,
  input logic [AW-1:0] ar_o,
  input logic [AW-1:0] pc_o,
  input logic          zero_o,
  input logic          sgn_o,
  input logic          mem_wr
);
  // R11: clear in the first field overrides any other accumulator action
  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (f1 == 3'd2) |=> (ac_o == '0) && zero_o);

  // R8: PC step wraps in AW bits
  assert_pc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (f3 == 3'd5) |=> (pc_o == AW'($past(pc_o) + 1)));

  // R3: AR takes the pre-edge PC
  assert_ar_from_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (f1 == 3'd6) |=> (ar_o == $past(pc_o)));

  // R6: DR takes the pre-edge accumulator
  assert_dr_from_ac_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (f2 == 3'd5) |=> (dr_o == $past(ac_o)));

  // R7: right shift with no competing accumulator action clears the top bit
  assert_shr_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((f3 == 3'd4) && (f1 == 3'd0 || f1 > 3'd4) && (f2 == 3'd0 || f2 > 3'd3))
    |=> !ac_o[DW-1]);

  // R12: all-NOP cycle holds every register
  assert_nop_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (f1 == 3'd0 && f2 == 3'd0 && f3 == 3'd0)
    |=> ($stable(ac_o) && $stable(dr_o) && $stable(ar_o) && $stable(pc_o)));

  // R4: write code always raises the memory write event
  assert_mem_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (f1 == 3'd7) |-> mem_wr);

  // R10: sign and zero flags are mutually exclusive
  assert_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sgn_o |-> !zero_o);
endmodule

bind mpdp_top mpdp_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .f1(f1), .f2(f2), .f3(f3),
  .ac_o(ac_o), .dr_o(dr_o), .ar_o(ar_o), .pc_o(pc_o),
  .zero_o(zero_o), .sgn_o(sgn_o), .mem_wr(mem_wr));

// File: tb/tb_mpdp_top.sv
`timescale 1ns/1ps
module tb_mpdp_top;
  localparam int DW = 16;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] f1 = '0, f2 = '0, f3 = '0;
  logic [DW-1:0] ac_o, dr_o;
  logic [AW-1:0] ar_o, pc_o;
  logic ind_o, sgn_o, zero_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference state
  logic [DW-1:0] m_ac = '0, m_dr = '0;
  logic [AW-1:0] m_ar = '0, m_pc = '0;
  logic [DW-1:0] m_mem [DEPTH];

  always #5 clk = ~clk;

  mpdp_top dut (
    .clk(clk), .rst_n(rst_n), .f1(f1), .f2(f2), .f3(f3),
    .ac_o(ac_o), .dr_o(dr_o), .ar_o(ar_o), .pc_o(pc_o),
    .ind_o(ind_o), .sgn_o(sgn_o), .zero_o(zero_o));

  // reference update: weakest field first so the first field overwrites last
  task automatic model(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c);
    logic [DW-1:0] n_ac, n_dr;
    logic [AW-1:0] n_ar, n_pc;
    n_ac = m_ac; n_dr = m_dr; n_ar = m_ar; n_pc = m_pc;
    case (c)
      3'd1: n_ac = m_ac ^ m_dr;
      3'd2: n_ac = ~m_ac;
      3'd3: n_ac = m_ac << 1;
      3'd4: n_ac = m_ac >> 1;
      3'd5: n_pc = m_pc + 1'b1;
      3'd6: n_pc = m_ar;
      default: ;
    endcase
    case (b)
      3'd1: n_ac = m_ac - m_dr;
      3'd2: n_ac = m_ac | m_dr;
      3'd3: n_ac = m_ac & m_dr;
      3'd4: n_dr = m_mem[m_ar];
      3'd5: n_dr = m_ac;
      3'd6: n_dr = m_dr + 1'b1;
      3'd7: n_dr[AW-1:0] = m_pc;
      default: ;
    endcase
    case (a)
      3'd1: n_ac = m_ac + m_dr;
      3'd2: n_ac = '0;
      3'd3: n_ac = m_ac + 1'b1;
      3'd4: n_ac = m_dr;
      3'd5: n_ar = m_dr[AW-1:0];
      3'd6: n_ar = m_pc;
      3'd7: m_mem[m_ar] = m_dr;
      default: ;
    endcase
    m_ac = n_ac; m_dr = n_dr; m_ar = n_ar; m_pc = n_pc;
  endtask

  task automatic check_regs(input string tag);
    checks++;
    if (ac_o !== m_ac || dr_o !== m_dr || ar_o !== m_ar || pc_o !== m_pc) begin
      errors++;
      $display("FAIL %s regs: ac=%h dr=%h ar=%h pc=%h expected ac=%h dr=%h ar=%h pc=%h",
               tag, ac_o, dr_o, ar_o, pc_o, m_ac, m_dr, m_ar, m_pc);
    end
  endtask

  task automatic check_flags(input string tag);
    logic [2:0] exp_f;
    exp_f = {m_dr[DW-1], m_ac[DW-1], m_ac == '0};
    checks++;
    if ({ind_o, sgn_o, zero_o} !== exp_f) begin
      errors++;
      $display("FAIL %s flags(ind,sgn,zero): actual=%b expected=%b",
               tag, {ind_o, sgn_o, zero_o}, exp_f);
    end
  endtask

  task automatic step(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c,
                      input string tag);
    @(negedge clk);
    f1 = a; f2 = b; f3 = c;
    model(a, b, c);
    @(posedge clk);
    #1;
    check_regs(tag);
  endtask

  function automatic int ac_hits(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c);
    return int'(a >= 3'd1 && a <= 3'd4) + int'(b >= 3'd1 && b <= 3'd3)
         + int'(c >= 3'd1 && c <= 3'd4);
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
  end

  // watchdog
  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] a, b, c;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check_regs("R1 reset");
    check_flags("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;

    // accumulator wrap and flags
    step(3'd0, 3'd0, 3'd2, "R7 not");          // AC=FFFF
    check_flags("R10 sign");
    step(3'd0, 3'd0, 3'd4, "R7 shr zero fill"); // AC=7FFF
    step(3'd0, 3'd0, 3'd2, "R7 not again");     // AC=8000
    step(3'd0, 3'd0, 3'd3, "R7 shl zero fill"); // AC=0
    check_flags("R10 zero");
    step(3'd0, 3'd0, 3'd2, "R7 not");           // AC=FFFF
    step(3'd3, 3'd0, 3'd0, "R2 inc wrap");      // AC=0
    check_flags("R10 zero after wrap");
    step(3'd0, 3'd6, 3'd0, "R6 dr inc");        // DR=1
    step(3'd0, 3'd1, 3'd0, "R5 sub wrap");      // AC=FFFF
    check_flags("R5 sign after sub");
    step(3'd0, 3'd5, 3'd0, "R6 dr from ac");    // DR=FFFF
    check_flags("R10 ind");
    step(3'd5, 3'd0, 3'd0, "R3 ar from dr");    // AR=7FF
    step(3'd0, 3'd0, 3'd6, "R8 pc from ar");    // PC=7FF
    step(3'd0, 3'd0, 3'd5, "R8 pc wrap");       // PC=0
    step(3'd0, 3'd7, 3'd0, "R6 dr low from pc keeps top"); // DR=F800
    step(3'd0, 3'd0, 3'd7, "R8 reserved code");
    step(3'd0, 3'd0, 3'd0, "R12 nop");
    step(3'd7, 3'd0, 3'd0, "R4 write");         // M[7FF]=F800
    step(3'd2, 3'd5, 3'd0, "R9 clear ac and dr from old ac"); // DR=FFFF, AC=0
    step(3'd6, 3'd4, 3'd5, "R9 read, ar from pc, pc inc");   // DR=F800, AR=0, PC=1
    step(3'd2, 3'd0, 3'd2, "R11 priority clear over not");
    step(3'd4, 3'd2, 3'd0, "R11 priority load over or");

    // constrained random microinstructions with no accumulator conflicts
    for (int n = 0; n < 3000; n++) begin
      do begin
        a = 3'($urandom_range(7));
        b = 3'($urandom_range(7));
        c = 3'($urandom_range(7));
      end while (ac_hits(a, b, c) > 1);
      step(a, b, c, "R9 random");
      if (n % 8 == 0) check_flags("R10 random");
    end

    // bring every field table back through one more directed sweep
    for (int op = 1; op < 8; op++) begin
      step(3'(op), 3'd0, 3'd0, "R2 sweep f1");
      step(3'd0, 3'(op), 3'd0, "R5 sweep f2");
      step(3'd0, 3'd0, 3'(op), "R8 sweep f3");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule